// File: doc/BRIEF.md
# Video Interrupt Priority Controller

This block merges two video interrupt sources, one raised once per frame at the start of vertical blanking and one raised by the line counter, into a single processor interrupt level. Each source has a pending flag. A one-cycle set strobe from the timing logic raises the flag. A per-source enable bit from the video control registers decides whether a pending flag is eligible to interrupt. The vertical source always wins, so the output level is the vertical level, the horizontal level, or zero.

When the processor acknowledges, the block clears only the source it is servicing. If the vertical source was eligible, the block clears that source and pulses a strobe that clears the vertical-interrupt bit of the status register. It then keeps the horizontal request if that request is pending and enabled, and drops the request otherwise. If the vertical source was not eligible, the acknowledge clears the horizontal flag. The output level is recomputed combinationally from the registered flags, so a change of an enable bit shows at the output in the same cycle.

Top module: `vid_irq_prio`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both pending flags. While `rst` is high, `irq_level` is 0 and `vflag_clr` is 0.
- R2: When the vertical flag is pending and `vert_en` is 1, `irq_level` is 6 (binary 110), whatever the state of the horizontal source. A `vert_set` strobe sampled at one rising edge makes the flag pending from that edge on.
- R3: When the vertical source is not eligible and the horizontal flag is pending with `horz_en` at 1, `irq_level` is 4 (binary 100).
- R4: When neither source is eligible, `irq_level` is 0. A disabled pending flag is kept, and `irq_level` follows an enable change in the same cycle.
- R5: An `irq_ack` while the vertical source is eligible clears the vertical flag at the next edge. In that same cycle `vflag_clr` is 1, for one cycle only.
- R6: After a vertical acknowledge, a horizontal flag that was pending and enabled is kept, so `irq_level` becomes 4.
- R7: After a vertical acknowledge, a horizontal flag that was pending but disabled is dropped, so enabling it later gives level 0.
- R8: An `irq_ack` while the vertical source is not eligible clears the horizontal flag, leaves the vertical flag untouched and keeps `vflag_clr` at 0.
- R9: A set strobe and an acknowledge that would clear the same source in the same cycle leave that source pending.
- R10: `vflag_clr` is never 1 in a cycle without `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vert_set | input | 1 | One-cycle strobe that marks the vertical interrupt as pending |
| horz_set | input | 1 | One-cycle strobe that marks the horizontal interrupt as pending |
| vert_en | input | 1 | Vertical interrupt enable bit from the control register |
| horz_en | input | 1 | Horizontal interrupt enable bit from the control register |
| irq_ack | input | 1 | Processor interrupt acknowledge pulse |
| irq_level | output | LEVEL_W (3) | Encoded interrupt level: 6, 4 or 0 |
| vflag_clr | output | 1 | Strobe that clears the vertical-interrupt status flag |

## Verification
The bench aims at the acknowledge ordering. It covers a vertical acknowledge with the horizontal source pending and enabled, and with it pending but disabled. A design that always cleared both flags would drop the level to 0 instead of 4. A design that never dropped a disabled horizontal flag would show level 4 once that source is enabled. The bench also acknowledges with the vertical source pending but disabled. A design that tested pending alone would clear the wrong flag and pulse the status clear. Finally, it raises and acknowledges the same source in one cycle. A design that let the clear win would lose the new event and fall to level 0.

// File: rtl/vip_pkg.sv
package vip_pkg;
   localparam int NUM_SRC  = 2;
   localparam int SRC_VERT = 0;
   localparam int SRC_HORZ = 1;
endpackage

// File: rtl/vip_pend_flag.sv
module vip_pend_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);
   // a new event outranks a clear in the same cycle
   always_ff @(posedge clk) begin
      if (rst)
         pend_o <= 1'b0;
      else if (set_i)
         pend_o <= 1'b1;
      else if (clr_i)
         pend_o <= 1'b0;
   end
endmodule

// File: rtl/vip_prio_enc.sv
module vip_prio_enc
   import vip_pkg::*;
#(
   parameter int LEVEL_W    = 3,
   parameter int VERT_LEVEL = 6,
   parameter int HORZ_LEVEL = 4
) (
   input  logic [NUM_SRC-1:0] elig_i,
   input  logic               force_zero_i,
   output logic [LEVEL_W-1:0] level_o
);
   always_comb begin
      if (force_zero_i)
         level_o = '0;
      else if (elig_i[SRC_VERT])
         level_o = LEVEL_W'(VERT_LEVEL);
      else if (elig_i[SRC_HORZ])
         level_o = LEVEL_W'(HORZ_LEVEL);
      else
         level_o = '0;
   end
endmodule

// File: rtl/vip_ack_seq.sv
module vip_ack_seq
   import vip_pkg::*;
(
   input  logic               ack_i,
   input  logic               block_i,
   input  logic [NUM_SRC-1:0] elig_i,
   output logic [NUM_SRC-1:0] clr_o,
   output logic               vflag_clr_o
);
   logic vert_served;

   always_comb begin
      vert_served    = ack_i && elig_i[SRC_VERT];
      clr_o          = '0;
      clr_o[SRC_VERT] = vert_served;
      // horizontal survives only a vertical service while it is itself eligible
      clr_o[SRC_HORZ] = ack_i && !(elig_i[SRC_VERT] && elig_i[SRC_HORZ]);
      vflag_clr_o    = vert_served && !block_i;
   end
endmodule

// File: rtl/vid_irq_prio.sv
module vid_irq_prio
   import vip_pkg::*;
#(
   parameter int LEVEL_W    = 3,
   parameter int VERT_LEVEL = 6,
   parameter int HORZ_LEVEL = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               vert_set,
   input  logic               horz_set,
   input  logic               vert_en,
   input  logic               horz_en,
   input  logic               irq_ack,
   output logic [LEVEL_W-1:0] irq_level,
   output logic               vflag_clr
);
   localparam int LEVEL_MAX = (1 << LEVEL_W) - 1;

   if (LEVEL_W < 1) begin : g_bad_width
      $error("LEVEL_W must be at least 1");
   end
   if (VERT_LEVEL > LEVEL_MAX || HORZ_LEVEL > LEVEL_MAX) begin : g_bad_fit
      $error("interrupt levels do not fit LEVEL_W bits");
   end
   if (VERT_LEVEL <= HORZ_LEVEL || HORZ_LEVEL < 1) begin : g_bad_order
      $error("vertical level must exceed horizontal level, both non-zero");
   end

   logic [NUM_SRC-1:0] set_v;
   logic [NUM_SRC-1:0] en_v;
   logic [NUM_SRC-1:0] clr_v;
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] elig;

   always_comb begin
      set_v           = '0;
      en_v            = '0;
      set_v[SRC_VERT] = vert_set;
      set_v[SRC_HORZ] = horz_set;
      en_v[SRC_VERT]  = vert_en;
      en_v[SRC_HORZ]  = horz_en;
      elig            = pend_q & en_v;
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      vip_pend_flag u_flag (
         .clk    (clk),
         .rst    (rst),
         .set_i  (set_v[s]),
         .clr_i  (clr_v[s]),
         .pend_o (pend_q[s])
      );
   end

   vip_ack_seq u_ack (
      .ack_i       (irq_ack),
      .block_i     (rst),
      .elig_i      (elig),
      .clr_o       (clr_v),
      .vflag_clr_o (vflag_clr)
   );

   vip_prio_enc #(
      .LEVEL_W    (LEVEL_W),
      .VERT_LEVEL (VERT_LEVEL),
      .HORZ_LEVEL (HORZ_LEVEL)
   ) u_enc (
      .elig_i       (elig),
      .force_zero_i (rst),
      .level_o      (irq_level)
   );
endmodule

// File: rtl/vid_irq_prio_chk.sv
module vid_irq_prio_chk #(
   parameter int LEVEL_W    = 3,
   parameter int VERT_LEVEL = 6,
   parameter int HORZ_LEVEL = 4
) (
   input logic               clk,
   input logic               rst,
   input logic               vert_set,
   input logic               horz_set,
   input logic               vert_en,
   input logic               horz_en,
   input logic               irq_ack,
   input logic [LEVEL_W-1:0] irq_level,
   input logic               vflag_clr,
   input logic               vpend,
   input logic               hpend
);
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!vpend && !hpend));

   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |-> (irq_level == '0 && !vflag_clr));

   a_r2_vert_level: assert property (@(posedge clk) disable iff (rst)
      (vpend && vert_en) |-> (irq_level == LEVEL_W'(VERT_LEVEL)));

   a_r3_horz_level: assert property (@(posedge clk) disable iff (rst)
      (!(vpend && vert_en) && hpend && horz_en) |-> (irq_level == LEVEL_W'(HORZ_LEVEL)));

   a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
      (!(vpend && vert_en) && !(hpend && horz_en)) |-> (irq_level == '0));

   a_r5_vert_cleared: assert property (@(posedge clk) disable iff (rst)
      (vflag_clr && !vert_set) |=> !vpend);

   a_r6_horz_kept: assert property (@(posedge clk) disable iff (rst)
      (irq_ack && vpend && vert_en && hpend && horz_en) |=> hpend);

   a_r7_horz_dropped: assert property (@(posedge clk) disable iff (rst)
      (irq_ack && vpend && vert_en && hpend && !horz_en && !horz_set) |=> !hpend);

   a_r8_horz_acked: assert property (@(posedge clk) disable iff (rst)
      (irq_ack && !(vpend && vert_en) && !horz_set) |=> !hpend);

   a_r8_vert_untouched: assert property (@(posedge clk) disable iff (rst)
      (irq_ack && vpend && !vert_en) |=> vpend);

   a_r9_set_wins_vert: assert property (@(posedge clk) disable iff (rst)
      vert_set |=> vpend);

   a_r9_set_wins_horz: assert property (@(posedge clk) disable iff (rst)
      horz_set |=> hpend);

   a_r10_clr_needs_ack: assert property (@(posedge clk)
      vflag_clr |-> irq_ack);
endmodule

bind vid_irq_prio vid_irq_prio_chk #(
   .LEVEL_W    (LEVEL_W),
   .VERT_LEVEL (VERT_LEVEL),
   .HORZ_LEVEL (HORZ_LEVEL)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .vert_set  (vert_set),
   .horz_set  (horz_set),
   .vert_en   (vert_en),
   .horz_en   (horz_en),
   .irq_ack   (irq_ack),
   .irq_level (irq_level),
   .vflag_clr (vflag_clr),
   .vpend     (pend_q[0]),
   .hpend     (pend_q[1])
);

// File: tb/vid_irq_prio_test.sv
module vid_irq_prio_test;
   localparam int WD_CYC = 200000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       vert_set = 1'b0, horz_set = 1'b0;
   logic       vert_en = 1'b0, horz_en = 1'b0;
   logic       irq_ack = 1'b0;
   logic [2:0] irq_level;
   logic       vflag_clr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [2:0] lvl;
      logic       vf;
      string      tag;
   } exp_t;
   exp_t sbq[$];

   // reference state: pending flags as the requirements define them
   logic mv = 1'b0, mh = 1'b0;

   vid_irq_prio uut (
      .clk       (clk),
      .rst       (rst),
      .vert_set  (vert_set),
      .horz_set  (horz_set),
      .vert_en   (vert_en),
      .horz_en   (horz_en),
      .irq_ack   (irq_ack),
      .irq_level (irq_level),
      .vflag_clr (vflag_clr)
   );

   always #5 clk = ~clk;

   task automatic step(input logic r, input logic vs, input logic hs,
                       input logic ve, input logic he, input logic ak,
                       input string tag);
      exp_t e;
      logic ve_ok, he_ok, clr_v, clr_h;
      @(negedge clk);
      rst = r; vert_set = vs; horz_set = hs;
      vert_en = ve; horz_en = he; irq_ack = ak;
      #1;
      ve_ok = mv && ve;
      he_ok = mh && he;
      e.tag = tag;
      if (r) begin
         e.lvl = 3'd0; e.vf = 1'b0;
      end else begin
         e.lvl = ve_ok ? 3'd6 : (he_ok ? 3'd4 : 3'd0);
         e.vf  = ak && ve_ok;
      end
      sbq.push_back(e);
      clr_v = ak && ve_ok;
      clr_h = ak && !(ve_ok && he_ok);
      if (r) begin
         mv = 1'b0; mh = 1'b0;
      end else begin
         mv = vs || (mv && !clr_v);
         mh = hs || (mh && !clr_h);
      end
   endtask

   // monitor: compares each cycle's outputs with the queued expectation
   always @(negedge clk) begin
      exp_t got;
      #2;
      if (sbq.size() > 0) begin
         got = sbq.pop_front();
         checks++;
         if (irq_level !== got.lvl || vflag_clr !== got.vf) begin
            errors++;
            $display("FAIL %s: level=%0d vflag_clr=%0b expected level=%0d vflag_clr=%0b",
                     got.tag, irq_level, vflag_clr, got.lvl, got.vf);
         end
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      // R1: held in reset
      step(1, 0, 0, 1, 1, 0, "R1 reset level");
      step(1, 1, 1, 1, 1, 1, "R1 reset ignores strobes");
      step(0, 0, 0, 1, 1, 0, "R1 out of reset idle");
      // R4: idle
      step(0, 0, 0, 1, 1, 0, "R4 idle");
      // R2: vertical raises level 6, wins over horizontal
      step(0, 1, 0, 1, 1, 0, "R2 strobe cycle");
      step(0, 0, 1, 1, 1, 0, "R2 vertical level");
      step(0, 0, 0, 1, 1, 0, "R2 vertical beats horizontal");
      // R5/R6: vertical ack keeps enabled horizontal
      step(0, 0, 0, 1, 1, 1, "R5 vertical ack strobe");
      step(0, 0, 0, 1, 1, 0, "R6 horizontal kept after vertical ack");
      // R8: ack of horizontal
      step(0, 0, 0, 1, 1, 1, "R8 horizontal ack");
      step(0, 0, 0, 1, 1, 0, "R8 horizontal cleared");
      // R4: disabled flag held, enable shows same cycle
      step(0, 0, 1, 1, 0, 0, "R4 disabled set");
      step(0, 0, 0, 1, 0, 0, "R4 disabled pending gives 0");
      step(0, 0, 0, 1, 1, 0, "R4 enable shows level 4");
      // R3/R8: vertical pending but disabled
      step(0, 1, 0, 0, 1, 0, "R3 vertical set disabled");
      step(0, 0, 0, 0, 1, 0, "R3 horizontal level");
      step(0, 0, 0, 0, 1, 1, "R8 ack with vertical disabled");
      step(0, 0, 0, 0, 1, 0, "R8 horizontal gone");
      step(0, 0, 0, 1, 1, 0, "R8 vertical still pending");
      step(0, 0, 0, 1, 1, 1, "R5 vertical ack alone");
      step(0, 0, 0, 1, 1, 0, "R5 vertical cleared");
      // R7: vertical ack drops disabled horizontal
      step(0, 1, 1, 1, 0, 0, "R7 set both");
      step(0, 0, 0, 1, 0, 1, "R7 vertical ack");
      step(0, 0, 0, 1, 1, 0, "R7 horizontal dropped");
      // R9: set and ack together
      step(0, 1, 0, 1, 1, 0, "R9 vertical set");
      step(0, 1, 0, 1, 1, 1, "R9 vertical set with ack");
      step(0, 0, 0, 1, 1, 0, "R9 vertical still pending");
      step(0, 0, 0, 1, 1, 1, "R9 drain vertical");
      step(0, 0, 1, 1, 1, 0, "R9 horizontal set");
      step(0, 0, 1, 1, 1, 1, "R9 horizontal set with ack");
      step(0, 0, 0, 1, 1, 0, "R9 horizontal still pending");
      // R10: ack with nothing eligible
      step(0, 0, 0, 1, 1, 1, "R10 ack drains horizontal");
      step(0, 0, 0, 1, 1, 1, "R10 ack idle no strobe");
      // R1: reset mid-run with both pending
      step(0, 1, 1, 1, 1, 0, "R1 load both");
      step(1, 0, 0, 1, 1, 1, "R1 reset forces zero");
      step(0, 0, 0, 1, 1, 0, "R1 flags cleared");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule